// File: doc/BRIEF.md
# SMBus Packet Error Code Checker

This block keeps the running CRC-8 Packet Error Code of one SMBus message. It absorbs one byte per strobe, and every byte of the message counts, the address byte with its R/W bit included. The link controller beside it places each byte on `byte_in` as the byte crosses the wire. It pulses `msg_start` at every START and repeated START. It raises `pec_mark` on the byte that carries the code.

When the block transmits, the controller sends `crc_out` as the closing byte of the message. When it receives, the byte marked as the code is compared against the CRC of everything before it. A match raises a one-cycle ACK request. A mismatch raises a one-cycle NACK request and sets a sticky error flag, which stays set until it is cleared. Driving SDA and sequencing the bus are left to the controller.

Top module: `smb_pec_check`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `crc_out` equals 0x00 and `pec_err`, `ack_req` and `nack_req` are all 0.
- R2: A strobe (`byte_vld`=1, `pec_mark`=0, `msg_start`=0) folds `byte_in` into the CRC. The CRC uses the polynomial x^8+x^2+x+1 (0x07) and takes the byte MSB first, with no reflection and no final XOR. The new value shows on `crc_out` in the cycle after the strobe. From a cleared register, byte 0x00 gives 0x00 and byte 0x01 gives 0x07.
- R3: Every strobed byte of a message counts, address bytes included. From 0x00, the ASCII bytes "123456789" give 0xF4.
- R4: `msg_start`=1 loads 0x00 into the CRC in the next cycle. This takes priority over a strobe in the same cycle, and that byte is discarded.
- R5: With `byte_vld`=0 and `msg_start`=0, `crc_out` holds its value.
- R6: A received code byte (`byte_vld`=1, `pec_mark`=1, `dir_rx`=1, `msg_start`=0) that equals `crc_out` makes `ack_req` 1 for exactly the next cycle. The code byte is not folded into the CRC.
- R7: A received code byte that differs from `crc_out` makes `nack_req` 1 for exactly the next cycle and sets `pec_err`.
- R8: `pec_err` stays 1 until a cycle with `err_clr`=1. `msg_start` does not clear it. When a new mismatch arrives in the same cycle as `err_clr`, the flag stays set.
- R9: A code byte while transmitting (`dir_rx`=0) raises neither `ack_req` nor `nack_req`, and it leaves `crc_out` unchanged.
- R10: `ack_req` and `nack_req` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | START or repeated START seen; clears the CRC |
| byte_vld | input | 1 | Byte strobe, one cycle per byte |
| byte_in | input | 8 | Byte on the bus, address bytes included |
| pec_mark | input | 1 | The strobed byte is the packet error code |
| dir_rx | input | 1 | 1 when receiving, 0 when transmitting |
| err_clr | input | 1 | Clears the sticky error flag |
| crc_out | output | 8 | Running CRC; the code to append when transmitting |
| pec_err | output | 1 | Sticky mismatch flag |
| ack_req | output | 1 | One-cycle request to ACK the received code |
| nack_req | output | 1 | One-cycle request to NACK the received code |

## Verification
The bench builds the block with its default parameters: polynomial 0x07 and an initial value of 0x00. These are the values that SMBus fixes. With them the well-known CRC-8 check value for "123456789" (0xF4) can serve as an independent reference, alongside the single-byte vectors. The same settings let realistic address, command and data sequences be closed with both correct and corrupted code bytes.

// File: rtl/smb_pec_pkg.sv
package smb_pec_pkg;
    localparam int PEC_W = 8;

    typedef logic [PEC_W-1:0] pec_t;

    typedef struct packed {
        pec_t crc;
        logic err;
        logic ack;
        logic nack;
    } pec_state_t;
endpackage

// File: rtl/pec_crc_step.sv
// Folds one byte into the CRC, MSB first, as a chain of bit stages.
module pec_crc_step
    import smb_pec_pkg::*;
#(
    parameter pec_t POLY = 8'h07
) (
    input  pec_t crc_in,
    input  pec_t data_in,
    output pec_t crc_next
);
    localparam int W = PEC_W;

    logic [W:0][W-1:0] stage;

    assign stage[0] = crc_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][W-1] ^ data_in[W-1-i];
        assign stage[i+1] = fb ? ((stage[i] << 1) ^ POLY) : (stage[i] << 1);
    end

    assign crc_next = stage[W];
endmodule

// File: rtl/pec_verdict.sv
// Turns a received code byte into ACK or NACK requests.
module pec_verdict
    import smb_pec_pkg::*;
(
    input  logic check_en,
    input  pec_t rx_code,
    input  pec_t crc_exp,
    output logic ack_d,
    output logic nack_d
);
    logic same;

    assign same   = (rx_code == crc_exp);
    assign ack_d  = check_en & same;
    assign nack_d = check_en & ~same;
endmodule

// File: rtl/smb_pec_check.sv
module smb_pec_check
    import smb_pec_pkg::*;
#(
    parameter pec_t POLY     = 8'h07,
    parameter pec_t CRC_INIT = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       msg_start,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       pec_mark,
    input  logic       dir_rx,
    input  logic       err_clr,
    output logic [7:0] crc_out,
    output logic       pec_err,
    output logic       ack_req,
    output logic       nack_req
);
    localparam pec_state_t RST_STATE = '{crc: CRC_INIT, err: 1'b0, ack: 1'b0, nack: 1'b0};

    pec_state_t st_q, st_d;
    pec_t       crc_step_d;
    logic       chk_en_d, ack_d, nack_d;

    pec_crc_step #(.POLY(POLY)) u_step (
        .crc_in  (st_q.crc),
        .data_in (byte_in),
        .crc_next(crc_step_d)
    );

    assign chk_en_d = byte_vld & pec_mark & dir_rx & ~msg_start;

    pec_verdict u_verdict (
        .check_en(chk_en_d),
        .rx_code (byte_in),
        .crc_exp (st_q.crc),
        .ack_d   (ack_d),
        .nack_d  (nack_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.ack  = ack_d;
        st_d.nack = nack_d;
        if (err_clr) begin
            st_d.err = 1'b0;
        end
        if (nack_d) begin
            st_d.err = 1'b1;
        end
        if (msg_start) begin
            st_d.crc = CRC_INIT;
        end else if (byte_vld && !pec_mark) begin
            st_d.crc = crc_step_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_out  = st_q.crc;
    assign pec_err  = st_q.err;
    assign ack_req  = st_q.ack;
    assign nack_req = st_q.nack;
endmodule

// File: rtl/smb_pec_check_sva.sv
module smb_pec_check_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       msg_start,
    input logic       byte_vld,
    input logic       pec_mark,
    input logic       dir_rx,
    input logic       err_clr,
    input logic [7:0] crc_out,
    input logic       pec_err,
    input logic       ack_req,
    input logic       nack_req
);
    p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_start |=> (crc_out == 8'h00));

    p_idle_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !msg_start) |=> $stable(crc_out));

    p_code_not_folded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && pec_mark && !msg_start) |=> $stable(crc_out));

    p_nack_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nack_req |-> pec_err);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_err && !err_clr) |=> pec_err);

    p_tx_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && pec_mark && !dir_rx) |=> (!ack_req && !nack_req));

    p_excl_verdict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_req && nack_req));
endmodule

bind smb_pec_check smb_pec_check_sva u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .msg_start(msg_start),
    .byte_vld (byte_vld),
    .pec_mark (pec_mark),
    .dir_rx   (dir_rx),
    .err_clr  (err_clr),
    .crc_out  (crc_out),
    .pec_err  (pec_err),
    .ack_req  (ack_req),
    .nack_req (nack_req)
);

// File: tb/smb_pec_check_tb.sv
module smb_pec_check_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       pec_mark = 1'b0;
    logic       dir_rx = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] crc_out;
    logic       pec_err, ack_req, nack_req;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model = 8'h00;

    always #4 clk = ~clk;

    smb_pec_check u_dut (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .pec_mark(pec_mark), .dir_rx(dir_rx), .err_clr(err_clr),
        .crc_out(crc_out), .pec_err(pec_err), .ack_req(ack_req), .nack_req(nack_req)
    );

    // Reference from the requirement: poly 0x07, MSB first, no reflection.
    function automatic logic [7:0] crc_ref(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r = c ^ b;
        for (int k = 0; k < 8; k++) begin
            r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Inputs change at negedge; the registered result is read at the next negedge.
    task automatic cyc(input logic st, input logic v, input logic [7:0] b,
                       input logic pm, input logic rx, input logic clr);
        @(negedge clk);
        msg_start = st; byte_vld = v; byte_in = b; pec_mark = pm; dir_rx = rx; err_clr = clr;
        @(negedge clk);
        msg_start = 0; byte_vld = 0; pec_mark = 0; err_clr = 0;
    endtask

    task automatic start_msg();
        cyc(1, 0, 8'h00, 0, 0, 0);
        model = 8'h00;
    endtask

    task automatic put(input logic [7:0] b);
        cyc(0, 1, b, 0, 1, 0);
        model = crc_ref(model, b);
    endtask

    task automatic t_reset();
        rst_n = 0;
        #1;
        chk("R1 crc in reset", crc_out, 8'h00);
        chk("R1 flags in reset", {5'b0, pec_err, ack_req, nack_req}, 8'h00);
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 crc after reset", crc_out, 8'h00);
        chk("R1 flags after reset", {5'b0, pec_err, ack_req, nack_req}, 8'h00);
    endtask

    task automatic t_vectors();
        start_msg(); put(8'h00);
        chk("R2 crc(0x00)", crc_out, 8'h00);
        start_msg(); put(8'h01);
        chk("R2 crc(0x01)", crc_out, 8'h07);
        start_msg(); put(8'hB4);
        chk("R2 crc(0xB4)", crc_out, crc_ref(8'h00, 8'hB4));
    endtask

    task automatic t_check_value();
        string s = "123456789";
        start_msg();
        for (int i = 0; i < s.len(); i++) put(s[i]);
        chk("R3 check value", crc_out, 8'hF4);
        start_msg(); put(8'hB4); put(8'h10); put(8'hB5); put(8'h33); put(8'hC8);
        chk("R3 address and data", crc_out, model);
    endtask

    task automatic t_hold();
        start_msg(); put(8'h5A);
        repeat (3) cyc(0, 0, 8'hFF, 0, 1, 0);
        chk("R5 idle hold", crc_out, model);
    endtask

    task automatic t_start_priority();
        start_msg(); put(8'h21);
        cyc(1, 1, 8'h77, 0, 1, 0);
        chk("R4 start beats strobe", crc_out, 8'h00);
    endtask

    task automatic t_rx_match();
        start_msg(); put(8'hB4); put(8'h42); put(8'hB5); put(8'h9C);
        @(negedge clk);
        msg_start = 0; byte_vld = 1; byte_in = model; pec_mark = 1; dir_rx = 1;
        @(negedge clk);
        byte_vld = 0; pec_mark = 0;
        chk("R6 ack on match", {6'b0, ack_req, nack_req}, 8'h02);
        chk("R6 code not folded", crc_out, model);
        @(negedge clk);
        chk("R6 ack one cycle", {7'b0, ack_req}, 8'h00);
        chk("R6 no error", {7'b0, pec_err}, 8'h00);
    endtask

    task automatic t_rx_mismatch();
        start_msg(); put(8'hB4); put(8'h42);
        @(negedge clk);
        byte_vld = 1; byte_in = model ^ 8'h01; pec_mark = 1; dir_rx = 1;
        @(negedge clk);
        byte_vld = 0; pec_mark = 0;
        chk("R7 nack on mismatch", {6'b0, ack_req, nack_req}, 8'h01);
        chk("R7 error set", {7'b0, pec_err}, 8'h01);
        @(negedge clk);
        chk("R7 nack one cycle", {7'b0, nack_req}, 8'h00);
    endtask

    task automatic t_err_sticky();
        start_msg();
        chk("R8 held over start", {7'b0, pec_err}, 8'h01);
        repeat (2) cyc(0, 0, 8'h00, 0, 1, 0);
        chk("R8 held idle", {7'b0, pec_err}, 8'h01);
        cyc(0, 0, 8'h00, 0, 1, 1);
        chk("R8 cleared", {7'b0, pec_err}, 8'h00);
        start_msg(); put(8'h11);
        cyc(0, 1, model ^ 8'h80, 1, 1, 1);
        chk("R8 set beats clear", {7'b0, pec_err}, 8'h01);
        cyc(0, 0, 8'h00, 0, 1, 1);
        chk("R8 cleared again", {7'b0, pec_err}, 8'h00);
    endtask

    task automatic t_tx_pec();
        start_msg(); put(8'hB4); put(8'h07);
        cyc(0, 1, 8'hAA, 1, 0, 0);
        chk("R9 tx silent", {6'b0, ack_req, nack_req}, 8'h00);
        chk("R9 tx crc unchanged", crc_out, model);
        chk("R9 tx no error", {7'b0, pec_err}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_vectors();
        t_check_value();
        t_hold();
        t_start_priority();
        t_rx_match();
        t_rx_mismatch();
        t_err_sticky();
        t_tx_pec();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule